// File: doc/BRIEF.md
# Serial Command and Duty Port

This block is the host-facing port of a dimming controller. A host drives three lines: a shift clock, a framing line and a data line that can turn around. While the framing line is low, the block takes in 8-bit words, most significant bit first, one bit on each rising shift-clock edge. Bit 7 of the first word of a frame sets the frame type. A command frame carries the control fields: sensor bypass, fixed brightness index, standby, hold, reversed mapping, and the rate divider. A duty frame loads the eight 6-bit duty registers in sequence. The block oversamples all three lines with its own system clock.

Words are only staged while the frame is open. Nothing reaches the outputs until the framing line rises, and the frame is committed at that edge. The byte-count rules decide which staged words survive. When the framing line rises after a command frame, the data line turns into an output. It then returns a one-hot image of the currently selected duty register, one bit per shift clock, and goes back to an input when the framing line falls again.

Top module: `dim_serial_port`

## Requirements
- R1: While `reqIn` is low, `dataIn` is sampled on each rising edge of `sckIn`. Each group of eight samples forms one byte, and the first sample is bit 7.
- R2: No configuration or duty output changes while a frame is open. Staged bytes take effect only after `reqIn` rises.
- R3: A frame whose first byte has bit 7 = 0 is a command frame. In that first byte, bit 6 goes to `sensorOff`, bits 5..3 to `brightSel`, bit 2 to `standby`, bit 1 to `holdSel` and bit 0 to `reverseMap`.
- R4: The second byte of a command frame loads its bits 1..0 into `divideSel`. A command frame of one byte leaves `divideSel` unchanged.
- R5: If the third byte of a command frame is not 0x00, the whole frame is discarded. A third byte of 0x00 is accepted, and the fourth and later bytes are ignored.
- R6: A frame whose first byte has bit 7 = 1 is a duty frame. Its byte k (k = 0..7) writes bits 5..0 into duty register k, and bit 6 is ignored. Register k appears at `dutyFlat[6k+5:6k]`.
- R7: A duty frame of fewer than eight bytes updates only the registers it reached. Bytes after the eighth are ignored.
- R8: A trailing group of fewer than eight bits at the end of a frame is discarded. A frame with no complete byte changes nothing.
- R9: After a command frame with at least one complete byte, `dataOe` goes to 1 when `reqIn` rises. `dataOut` then shows bit 7 of the one-hot image of `selIdx`, in which bit i is 1 when `selIdx` = i. Each falling edge of `sckIn` moves to the next lower bit.
- R10: `dataOe` returns to 0 when `reqIn` falls. After a duty frame or an empty frame it stays at 0.
- R11: After reset all configuration outputs, all duty registers and `dataOe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Host shift clock, asynchronous |
| reqIn | input | 1 | Framing line: low = write, high = commit / read-back |
| dataIn | input | 1 | Data line as seen from the pad |
| selIdx | input | SEL_W (3) | Index of the currently selected duty register |
| dataOut | output | 1 | Read-back bit driven toward the pad |
| dataOe | output | 1 | Output enable for the data pad |
| sensorOff | output | 1 | Sensor bypass flag |
| brightSel | output | 3 | Fixed brightness register index |
| standby | output | 1 | Standby request |
| holdSel | output | 1 | Freeze current selection |
| reverseMap | output | 1 | Reverse sensor-to-register mapping |
| divideSel | output | 2 | Sampling / PWM rate divider |
| dutyFlat | output | NUM_REGS*DUTY_W (48) | Eight committed 6-bit duty values |

## Verification
Command frames of one, two, three and five bytes are sent. They show whether the second byte is taken, whether a nonzero third byte voids the frame while a zero one is accepted, and whether the bytes past the third are ignored. Duty frames of three, eight and ten bytes separate the partial-update case from the overflow case, and one duty byte sets bit 6 to show that bit has no effect. Frames ending in a stray partial byte, and frames with no complete byte, show that incomplete bits never commit. The read-back runs for two selection indices and checks the turnaround of the data line in both directions.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int BYTE_W = 8;

  // Strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic frameStart;  // framing line fell
    logic commit;      // framing line rose
    logic shiftIn;     // sample a write bit
    logic bitIn;       // the sampled bit
    logic byteDone;    // this sample completes a byte
    logic shiftOut;    // advance read-back bit
  } strobe_t;

  // Command fields, same packing as bits 6..0 of the first command byte
  typedef struct packed {
    logic       sensorOff;
    logic [2:0] bright;
    logic       standby;
    logic       hold;
    logic       reverse;
  } cmd_t;
endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckIn,
  input  logic             reqIn,
  input  logic             dataIn,
  output strobe_t          strb,
  output logic [IDX_W-1:0] byteIdx
);
  localparam int PIPE_W = SYNC_STAGES + 1;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [PIPE_W-1:0] sckPipe, reqPipe, datPipe;
  logic sckNow, sckPrev, reqNow, reqPrev, datNow;
  logic sckRise, sckFall, reqRise, reqFall;
  logic [BIT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      reqPipe <= '1;
      datPipe <= '0;
    end else begin
      sckPipe <= {sckPipe[PIPE_W-2:0], sckIn};
      reqPipe <= {reqPipe[PIPE_W-2:0], reqIn};
      datPipe <= {datPipe[PIPE_W-2:0], dataIn};
    end
  end

  assign sckNow  = sckPipe[SYNC_STAGES-1];
  assign sckPrev = sckPipe[SYNC_STAGES];
  assign reqNow  = reqPipe[SYNC_STAGES-1];
  assign reqPrev = reqPipe[SYNC_STAGES];
  assign datNow  = datPipe[SYNC_STAGES-1];

  assign sckRise = sckNow & ~sckPrev;
  assign sckFall = ~sckNow & sckPrev;
  assign reqRise = reqNow & ~reqPrev;
  assign reqFall = ~reqNow & reqPrev;

  always_comb begin
    strb.frameStart = reqFall;
    strb.commit     = reqRise;
    strb.shiftIn    = sckRise & ~reqNow;
    strb.bitIn      = datNow;
    strb.byteDone   = sckRise & ~reqNow & (bitCnt == BIT_W'(BYTE_W - 1));
    strb.shiftOut   = sckFall & reqNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (strb.frameStart) begin
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (strb.shiftIn) begin
      bitCnt <= bitCnt + 1'b1;
      if (strb.byteDone && byteIdx != IDX_MAX)
        byteIdx <= byteIdx + 1'b1;
    end
  end
endmodule

// File: rtl/dsp_datapath.sv
module dsp_datapath
  import dsp_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DUTY_W   = 6,
  parameter int IDX_W    = 5,
  parameter int SEL_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [IDX_W-1:0]           byteIdx,
  input  logic [SEL_W-1:0]           selIdx,
  output cmd_t                       cfg,
  output logic [1:0]                 divide,
  output logic [NUM_REGS*DUTY_W-1:0] dutyFlat,
  output logic                       dataOut,
  output logic                       dataOe
);
  logic [BYTE_W-1:0] rxShift, newByte;
  logic frameCmd, frameDuty, isDutyByte, isCmdByte;
  cmd_t stCmd1;
  logic [1:0] stDiv;
  logic haveCmd2, badThird;
  logic [NUM_REGS-1:0] stMask;
  logic [DUTY_W-1:0] stDuty [NUM_REGS];
  logic [NUM_REGS-1:0] readShift;
  logic readActive;

  assign newByte    = {rxShift[BYTE_W-2:0], strb.bitIn};
  assign isDutyByte = (byteIdx == '0) ? newByte[BYTE_W-1] : frameDuty;
  assign isCmdByte  = (byteIdx == '0) ? ~newByte[BYTE_W-1] : frameCmd;

  // Receive shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= newByte;
  end

  // Frame type and command staging
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCmd  <= 1'b0;
      frameDuty <= 1'b0;
      stCmd1    <= '0;
      stDiv     <= '0;
      haveCmd2  <= 1'b0;
      badThird  <= 1'b0;
    end else if (strb.frameStart) begin
      frameCmd  <= 1'b0;
      frameDuty <= 1'b0;
      haveCmd2  <= 1'b0;
      badThird  <= 1'b0;
    end else if (strb.byteDone) begin
      if (byteIdx == '0) begin
        frameCmd  <= ~newByte[BYTE_W-1];
        frameDuty <= newByte[BYTE_W-1];
      end
      if (isCmdByte) begin
        if (byteIdx == IDX_W'(0)) stCmd1 <= cmd_t'(newByte[6:0]);
        if (byteIdx == IDX_W'(1)) begin
          stDiv    <= newByte[1:0];
          haveCmd2 <= 1'b1;
        end
        if (byteIdx == IDX_W'(2)) badThird <= (newByte != '0);
      end
    end
  end

  // Committed command fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      divide <= '0;
    end else if (strb.commit && frameCmd && !badThird) begin
      cfg <= stCmd1;
      if (haveCmd2) divide <= stDiv;
    end
  end

  // Per-register duty staging and commit
  for (genvar k = 0; k < NUM_REGS; k++) begin : gDuty
    logic [DUTY_W-1:0] dutyReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stDuty[k] <= '0;
        stMask[k] <= 1'b0;
      end else if (strb.frameStart) begin
        stMask[k] <= 1'b0;
      end else if (strb.byteDone && isDutyByte && byteIdx == IDX_W'(k)) begin
        stDuty[k] <= newByte[DUTY_W-1:0];
        stMask[k] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dutyReg <= '0;
      else if (strb.commit && frameDuty && stMask[k]) dutyReg <= stDuty[k];
    end

    assign dutyFlat[k*DUTY_W +: DUTY_W] = dutyReg;
  end

  // Read-back: one-hot selection, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readShift  <= '0;
      readActive <= 1'b0;
    end else if (strb.frameStart) begin
      readActive <= 1'b0;
    end else if (strb.commit) begin
      readActive <= frameCmd;
      readShift  <= NUM_REGS'(1) << selIdx;
    end else if (strb.shiftOut && readActive) begin
      readShift <= {readShift[NUM_REGS-2:0], 1'b0};
    end
  end

  assign dataOut = readActive & readShift[NUM_REGS-1];
  assign dataOe  = readActive;
endmodule

// File: rtl/dim_serial_port.sv
module dim_serial_port
  import dsp_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int DUTY_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sckIn,
  input  logic                       reqIn,
  input  logic                       dataIn,
  input  logic [SEL_W-1:0]           selIdx,
  output logic                       dataOut,
  output logic                       dataOe,
  output logic                       sensorOff,
  output logic [2:0]                 brightSel,
  output logic                       standby,
  output logic                       holdSel,
  output logic                       reverseMap,
  output logic [1:0]                 divideSel,
  output logic [NUM_REGS*DUTY_W-1:0] dutyFlat
);
  localparam int IDX_W = $clog2(NUM_REGS) + 2;

  strobe_t          strb;
  logic [IDX_W-1:0] byteIdx;
  cmd_t             cfgBits;

  dsp_ctrl #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .reqIn(reqIn), .dataIn(dataIn),
    .strb(strb), .byteIdx(byteIdx)
  );

  dsp_datapath #(.NUM_REGS(NUM_REGS), .DUTY_W(DUTY_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .selIdx(selIdx),
    .cfg(cfgBits), .divide(divideSel), .dutyFlat(dutyFlat),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  assign sensorOff  = cfgBits.sensorOff;
  assign brightSel  = cfgBits.bright;
  assign standby    = cfgBits.standby;
  assign holdSel    = cfgBits.hold;
  assign reverseMap = cfgBits.reverse;
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker
  import dsp_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [IDX_W-1:0]  byteIdx,
  input cmd_t              cfgBits,
  input logic [1:0]        divideSel,
  input logic [DATA_W-1:0] dutyFlat,
  input logic              dataOut,
  input logic              dataOe
);
  AST_DUTY_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dutyFlat)); // R2
  AST_CFG_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(cfgBits) && $stable(divideSel))); // R2
  AST_RELEASE_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> !dataOe); // R10
  AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> (byteIdx == '0)); // R8
  AST_TURN_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(strb.commit)); // R9
  AST_READ_BIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && !strb.shiftOut && !strb.commit && !strb.frameStart) |=> $stable(dataOut)); // R9
endmodule

bind dim_serial_port dsp_checker #(.IDX_W(IDX_W), .DATA_W(NUM_REGS*DUTY_W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .byteIdx(byteIdx), .cfgBits(cfgBits),
  .divideSel(divideSel), .dutyFlat(dutyFlat), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/tb_dim_serial_port.sv
module tb_dim_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int WATCHDOG = 200000;

  typedef struct packed {
    logic [3:0]  nBytes;
    logic [2:0]  nPart;
    logic [7:0]  partBits;
    logic [79:0] bytes;     // byte 0 in the top 8 bits
    logic [6:0]  expCfg;    // {sensorOff, bright, standby, hold, reverse}
    logic [1:0]  expDiv;
    logic [63:0] expDuty;   // register k in bits [8k+5:8k]
    logic        expRead;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd0, 8'h00, 80'h45000000000000000000, 7'h45, 2'd0, 64'h0, 1'b1},  // R3
    '{4'd2, 3'd0, 8'h00, 80'h3A020000000000000000, 7'h3A, 2'd2, 64'h0, 1'b1},  // R4
    '{4'd3, 3'd0, 8'h00, 80'h12010000000000000000, 7'h12, 2'd1, 64'h0, 1'b1},  // R5 zero third
    '{4'd3, 3'd0, 8'h00, 80'h7F030500000000000000, 7'h12, 2'd1, 64'h0, 1'b1},  // R5 voided
    '{4'd5, 3'd0, 8'h00, 80'h210300FFAA0000000000, 7'h21, 2'd3, 64'h0, 1'b1},  // R5 fourth ignored
    '{4'd8, 3'd0, 8'h00, 80'h818283C5858687880000, 7'h21, 2'd3, 64'h0807060505030201, 1'b0}, // R6
    '{4'd3, 3'd0, 8'h00, 80'hBF80EA00000000000000, 7'h21, 2'd3, 64'h08070605052A003F, 1'b0}, // R7
    '{4'd10, 3'd0, 8'h00, 80'h91929394959697989F9F, 7'h21, 2'd3, 64'h1817161514131211, 1'b0}, // R7
    '{4'd1, 3'd5, 8'hB0, 80'h08000000000000000000, 7'h08, 2'd3, 64'h1817161514131211, 1'b1}, // R8
    '{4'd2, 3'd4, 8'hF0, 80'hA5800000000000000000, 7'h08, 2'd3, 64'h1817161514130025, 1'b0}, // R8
    '{4'd0, 3'd0, 8'h00, 80'h0, 7'h08, 2'd3, 64'h1817161514130025, 1'b0}                      // R8
  };

  logic clk = 0, rstN = 0, sckIn = 0, reqIn = 1, dataIn = 0;
  logic [2:0] selIdx = 0;
  logic dataOut, dataOe, sensorOff, standby, holdSel, reverseMap;
  logic [2:0] brightSel;
  logic [1:0] divideSel;
  logic [47:0] dutyFlat;
  int errors = 0, checks = 0, cycles = 0;

  dim_serial_port dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .reqIn(reqIn), .dataIn(dataIn),
    .selIdx(selIdx), .dataOut(dataOut), .dataOe(dataOe), .sensorOff(sensorOff),
    .brightSel(brightSel), .standby(standby), .holdSel(holdSel),
    .reverseMap(reverseMap), .divideSel(divideSel), .dutyFlat(dutyFlat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        checks++;
        $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  function automatic logic [6:0] cfgNow();
    return {sensorOff, brightSel, standby, holdSel, reverseMap};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    dataIn = b;
    waitCyc(HALF);
    sckIn = 1;
    waitCyc(HALF);
    sckIn = 0;
  endtask

  task automatic startFrame();
    reqIn = 0;
    waitCyc(HALF);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic endFrame();
    waitCyc(HALF);
    reqIn = 1;
    waitCyc(10);
  endtask

  task automatic readBack(input logic [7:0] exp, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(HALF);
      got[i] = dataOut;
      sckIn = 1;
      waitCyc(HALF);
      sckIn = 0;
    end
    check(got == exp, req, 64'(got), 64'(exp));
  endtask

  initial begin
    waitCyc(3);
    rstN = 1;
    waitCyc(3);
    // R11 reset state
    check(cfgNow() == 7'h0, "R11 cfg", 64'(cfgNow()), 64'h0);
    check(divideSel == 2'd0, "R11 divide", 64'(divideSel), 64'h0);
    check(dutyFlat == '0, "R11 duty", 64'(dutyFlat), 64'h0);
    check(dataOe == 1'b0, "R11 dataOe", 64'(dataOe), 64'h0);

    // Vector table: R1 R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      startFrame();
      for (int b = 0; b < int'(VECS[v].nBytes); b++)
        sendByte(VECS[v].bytes[79 - 8*b -: 8]);
      for (int p = 0; p < int'(VECS[v].nPart); p++)
        sendBit(VECS[v].partBits[7 - p]);
      endFrame();
      check(cfgNow() == VECS[v].expCfg, $sformatf("R3/R5 cfg vec%0d", v),
            64'(cfgNow()), 64'(VECS[v].expCfg));
      check(divideSel == VECS[v].expDiv, $sformatf("R4 divide vec%0d", v),
            64'(divideSel), 64'(VECS[v].expDiv));
      for (int k = 0; k < 8; k++)
        check(dutyFlat[6*k +: 6] == VECS[v].expDuty[8*k +: 6],
              $sformatf("R6/R7 duty%0d vec%0d", k, v),
              64'(dutyFlat[6*k +: 6]), 64'(VECS[v].expDuty[8*k +: 6]));
      check(dataOe == VECS[v].expRead, $sformatf("R9/R10 dataOe vec%0d", v),
            64'(dataOe), 64'(VECS[v].expRead));
    end

    // R2: a complete byte inside an open frame does not reach the outputs
    startFrame();
    sendByte(8'h55);
    waitCyc(8);
    check(cfgNow() == 7'h08, "R2 cfg before commit", 64'(cfgNow()), 64'h08);
    check(dataOe == 1'b0, "R10 released while frame open", 64'(dataOe), 64'h0);
    endFrame();
    check(cfgNow() == 7'h55, "R2 cfg after commit", 64'(cfgNow()), 64'h55);

    // R9: read-back of the one-hot selection, MSB first
    selIdx = 3'd4;
    startFrame();
    sendByte(8'h08);
    endFrame();
    check(dataOe == 1'b1, "R9 turnaround", 64'(dataOe), 64'h1);
    readBack(8'h10, "R9 readback sel4");

    // R10: falling framing line releases the data line
    reqIn = 0;
    waitCyc(8);
    check(dataOe == 1'b0, "R10 release", 64'(dataOe), 64'h0);
    reqIn = 1;
    waitCyc(10);
    check(dataOe == 1'b0, "R8 empty frame no readback", 64'(dataOe), 64'h0);

    selIdx = 3'd0;
    startFrame();
    sendByte(8'h08);
    sendByte(8'h01);
    endFrame();
    readBack(8'h01, "R9 readback sel0");
    check(divideSel == 2'd1, "R4 divide after readback frame", 64'(divideSel), 64'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule